// File: doc/BRIEF.md
# Debug Mailbox Channel

This block is a two-way 32-bit message channel between a processor and an external debug emulator. Each direction has its own data register. The processor fills the outbound register and the emulator drains it. The emulator fills the inbound register and the processor drains it.

Each direction has a "dirty" flag. The producer's write sets it, and the consumer's read clears it. A separate acknowledge flag records that the emulator has taken outbound data. The acknowledge flag stays set until the processor explicitly clears it.

Two enable bits choose which of two conditions drives a single level-sensitive interrupt request to the processor. The first condition is "acknowledge set", and the second is "inbound data dirty". The processor reaches the block through a small word-addressed register port. The emulator has separate read and write strobes and a side-effect-free view of the three flags. Both sides share one clock.

Top module: `dbg_mailbox_top`

## Requirements
- R1: After a synchronous reset, the following are all 0: both data registers, all three flags, both enables, `cpu_rdata`, `emu_rdata` and `irq`.
- R2: A processor write to offset 0x0 stores the outbound word and sets `emu_status[0]` (outbound dirty). An emulator read returns that word on `emu_rdata` one cycle later and clears `emu_status[0]`.
- R3: An emulator write stores the inbound word and sets `emu_status[1]` (inbound dirty). A processor read of offset 0x4 returns that word one cycle later and clears `emu_status[1]`.
- R4: An emulator read sets `emu_status[2]` (acknowledge). The only way to clear it is a processor write to offset 0x8 with bit 2 of the write data at 0. A write with bit 2 at 1 leaves it set.
- R5: The processor cannot change the inbound word by writing offset 0x4. Writes to bits 0 and 1 of offset 0x8 have no effect.
- R6: Offset 0xC holds two enables, and reads of offset 0xC return them with bits 31:2 at 0. Bit 1 enables the acknowledge interrupt, and bit 0 enables the inbound-dirty interrupt.
- R7: `irq` equals (acknowledge AND enable bit 1) OR (inbound dirty AND enable bit 0), taken from the state of the previous cycle. It is a registered level.
- R8: When a set event and a clear event hit the same flag in one cycle, the flag ends up set.
- R9: A read of offset 0x8 returns {29'b0, acknowledge, inbound dirty, outbound dirty}. `cpu_rdata` and `emu_rdata` hold their value in cycles without a read. Watching `emu_status` changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor byte address; bits 1:0 ignored |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, valid the cycle after `cpu_rd` |
| emu_wr | input | 1 | Emulator write strobe for the inbound word |
| emu_rd | input | 1 | Emulator read strobe for the outbound word |
| emu_wdata | input | DATA_W | Emulator write data |
| emu_rdata | output | DATA_W | Outbound word, valid the cycle after `emu_rd` |
| emu_status | output | 3 | {acknowledge, inbound dirty, outbound dirty} |
| irq | output | 1 | Registered interrupt request level |

## Verification
Directed sequences cover each flag in isolation: one producer write followed by one consumer read. Simultaneous set and clear events then show whether set priority is honoured on every flag. A status write with bit 2 at 1, and a write to the inbound offset, separate real clears from ignored writes. A long run of random mixed strobes on both ports, with random enables, is compared every cycle against a bench model. This run exposes wrong read latency, lost holds of the read data, and interrupt terms that track the wrong flag or the wrong cycle.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  typedef enum logic [2:0] {SEL_OUT, SEL_IN, SEL_STAT, SEL_CTRL, SEL_NONE} reg_sel_e;

  localparam int unsigned NFLAGS = 3;
  // status bit positions (processor view and emulator view)
  localparam int unsigned FL_ODIRTY = 0;
  localparam int unsigned FL_IDIRTY = 1;
  localparam int unsigned FL_ACK    = 2;
  // control bit positions
  localparam int unsigned EN_IDIRTY = 0;
  localparam int unsigned EN_ACK    = 1;
  localparam int unsigned NEN       = 2;
endpackage

// File: rtl/dbg_mbox_decode.sv
module dbg_mbox_decode
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    case (word)
      WORD_W'(0): sel = SEL_OUT;
      WORD_W'(1): sel = SEL_IN;
      WORD_W'(2): sel = SEL_STAT;
      WORD_W'(3): sel = SEL_CTRL;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dbg_mbox_flags.sv
module dbg_mbox_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_evt,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             q[i] <= 1'b0;
      else if (set_evt[i]) q[i] <= 1'b1;   // set has priority
      else if (clr_evt[i]) q[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> q[i]);
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
      (clr_evt[i] && !set_evt[i]) |=> !q[i]);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!clr_evt[i] && !set_evt[i]) |=> (q[i] == $past(q[i])));
  end
endmodule

// File: rtl/dbg_mbox_irq.sv
module dbg_mbox_irq
  import dbg_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] flags,
  input  logic [NEN-1:0]    en,
  output logic              irq
);
  logic req_d;
  assign req_d = (flags[FL_ACK] & en[EN_ACK]) | (flags[FL_IDIRTY] & en[EN_IDIRTY]);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= req_d;
  end

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!flags[FL_ACK] && !flags[FL_IDIRTY]) |=> !irq);
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/dbg_mailbox_top.sv
module dbg_mailbox_top
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              emu_wr,
  input  logic              emu_rd,
  input  logic [DATA_W-1:0] emu_wdata,
  output logic [DATA_W-1:0] emu_rdata,
  output logic [NFLAGS-1:0] emu_status,
  output logic              irq
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] out_q, in_q;
  logic [NEN-1:0]    en_q;
  logic [NFLAGS-1:0] flags, set_evt, clr_evt;
  logic              wr_out, wr_stat, wr_ctrl, rd_in;

  dbg_mbox_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(cpu_addr), .sel(sel));

  assign wr_out  = cpu_wr && (sel == SEL_OUT);
  assign wr_stat = cpu_wr && (sel == SEL_STAT);
  assign wr_ctrl = cpu_wr && (sel == SEL_CTRL);
  assign rd_in   = cpu_rd && (sel == SEL_IN);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      in_q  <= '0;
      en_q  <= '0;
    end else begin
      if (wr_out)  out_q <= cpu_wdata;
      if (emu_wr)  in_q  <= emu_wdata;
      if (wr_ctrl) en_q  <= cpu_wdata[NEN-1:0];
    end
  end

  always_comb begin
    set_evt            = '0;
    clr_evt            = '0;
    set_evt[FL_ODIRTY] = wr_out;
    clr_evt[FL_ODIRTY] = emu_rd;
    set_evt[FL_IDIRTY] = emu_wr;
    clr_evt[FL_IDIRTY] = rd_in;
    set_evt[FL_ACK]    = emu_rd;
    clr_evt[FL_ACK]    = wr_stat && !cpu_wdata[FL_ACK];
  end

  dbg_mbox_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_evt(clr_evt), .q(flags)
  );

  dbg_mbox_irq u_irq (.clk(clk), .rst(rst), .flags(flags), .en(en_q), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      emu_rdata <= '0;
    end else begin
      if (cpu_rd) begin
        case (sel)
          SEL_OUT:  cpu_rdata <= out_q;
          SEL_IN:   cpu_rdata <= in_q;
          SEL_STAT: cpu_rdata <= DATA_W'(flags);
          SEL_CTRL: cpu_rdata <= DATA_W'(en_q);
          default:  cpu_rdata <= '0;
        endcase
      end
      if (emu_rd) emu_rdata <= out_q;
    end
  end

  assign emu_status = flags;

  p_ctrl_rsv_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && sel == SEL_CTRL) |=> (cpu_rdata[DATA_W-1:NEN] == '0));
  p_ack_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (emu_status[FL_ACK] && !(cpu_wr && sel == SEL_STAT && !cpu_wdata[FL_ACK]))
      |=> emu_status[FL_ACK]);
  p_in_ro_r5: assert property (@(posedge clk) disable iff (rst)
    !emu_wr |=> (in_q == $past(in_q)));
  p_emu_rd_r2: assert property (@(posedge clk) disable iff (rst)
    emu_rd |=> (emu_rdata == $past(out_q)));
endmodule

// File: tb/test_dbg_mailbox_top.sv
`timescale 1ns/1ps
module test_dbg_mailbox_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, emu_wr = 1'b0, emu_rd = 1'b0;
  logic [31:0] cpu_wdata = '0, emu_wdata = '0;
  logic [31:0] cpu_rdata, emu_rdata;
  logic [2:0]  emu_status;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_out, m_in, m_crd, m_erd;
  logic [1:0]  m_en;
  logic        m_od, m_id, m_ack, m_irq;

  always #2.5 clk = ~clk;

  dbg_mailbox_top i_dbg_mailbox_top (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .emu_wr(emu_wr), .emu_rd(emu_rd),
    .emu_wdata(emu_wdata), .emu_rdata(emu_rdata), .emu_status(emu_status), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return m_out;
      2'd1:    return m_in;
      2'd2:    return {29'b0, m_ack, m_id, m_od};
      default: return {30'b0, m_en};
    endcase
  endfunction

  task automatic model_reset();
    m_out = '0; m_in = '0; m_crd = '0; m_erd = '0; m_en = '0;
    m_od = 0; m_id = 0; m_ack = 0; m_irq = 0;
  endtask

  task automatic step(input string tag, input logic cw, input logic cr, input logic [3:0] ca,
                      input logic [31:0] cd, input logic ew, input logic er, input logic [31:0] ed);
    logic [1:0] w;
    cpu_wr = cw; cpu_rd = cr; cpu_addr = ca; cpu_wdata = cd;
    emu_wr = ew; emu_rd = er; emu_wdata = ed;
    w = ca[3:2];
    // next state from requirements
    if (cr) m_crd = model_read(ca);
    if (er) m_erd = m_out;
    m_irq = (m_ack & m_en[1]) | (m_id & m_en[0]);
    m_od  = (cw && w == 0) ? 1'b1 : (er ? 1'b0 : m_od);
    m_id  = ew ? 1'b1 : ((cr && w == 1) ? 1'b0 : m_id);
    m_ack = er ? 1'b1 : ((cw && w == 2 && !cd[2]) ? 1'b0 : m_ack);
    if (cw && w == 0) m_out = cd;
    if (ew) m_in = ed;
    if (cw && w == 3) m_en = cd[1:0];
    @(posedge clk);
    #1;
    cpu_wr = 0; cpu_rd = 0; emu_wr = 0; emu_rd = 0;
    chk(tag, "cpu_rdata", cpu_rdata, m_crd);
    chk(tag, "emu_rdata", emu_rdata, m_erd);
    chk(tag, "emu_status", {29'b0, emu_status}, {29'b0, m_ack, m_id, m_od});
    chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 4'h0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1", "cpu_rdata", cpu_rdata, 0);
    chk("R1", "emu_rdata", emu_rdata, 0);
    chk("R1", "emu_status", {29'b0, emu_status}, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
    step("R1", 0, 1, 4'h0, 0, 0, 0, 0);
    step("R1", 0, 1, 4'hC, 0, 0, 0, 0);

    // R2 outbound path
    step("R2", 1, 0, 4'h0, 32'hCAFE_0001, 0, 0, 0);
    step("R9", 0, 0, 4'h0, 0, 0, 0, 0);           // status watched, no change
    step("R2", 0, 0, 4'h0, 0, 0, 1, 0);
    idle("R9");
    // R4 acknowledge: write 1 keeps it, write 0 clears
    step("R4", 1, 0, 4'h8, 32'h0000_0007, 0, 0, 0);
    step("R9", 0, 1, 4'h8, 0, 0, 0, 0);
    step("R4", 1, 0, 4'h8, 32'h0000_0000, 0, 0, 0);
    // R3 inbound path
    step("R3", 0, 0, 4'h0, 0, 1, 0, 32'h1234_5678);
    step("R5", 1, 0, 4'h4, 32'hDEAD_BEEF, 0, 0, 0); // write to inbound ignored
    step("R5", 1, 0, 4'h8, 32'h0000_0003, 0, 0, 0); // dirty bits not writable
    step("R3", 0, 1, 4'h4, 0, 0, 0, 0);
    step("R5", 0, 1, 4'h8, 0, 0, 0, 0);
    // R6 control
    step("R6", 1, 0, 4'hC, 32'hFFFF_FFFF, 0, 0, 0);
    step("R6", 0, 1, 4'hC, 0, 0, 0, 0);
    // R7 irq from acknowledge and from inbound dirty
    step("R7", 0, 0, 4'h0, 0, 0, 1, 0);
    idle("R7");
    step("R7", 1, 0, 4'h8, 0, 0, 0, 0);
    idle("R7");
    step("R7", 0, 0, 4'h0, 0, 1, 0, 32'h5);
    idle("R7");
    step("R7", 1, 0, 4'hC, 32'h2, 0, 0, 0);
    idle("R7");
    step("R7", 1, 0, 4'hC, 32'h1, 0, 1, 0);
    idle("R7");
    // R8 set wins on every flag
    step("R8", 1, 0, 4'h0, 32'hA5A5_A5A5, 0, 1, 0);  // outbound dirty set+clr
    step("R8", 0, 1, 4'h4, 0, 1, 0, 32'h77);         // inbound dirty set+clr
    step("R8", 1, 0, 4'h8, 0, 0, 1, 0);              // ack set+clr
    idle("R8");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] a;
      a = {2'($urandom % 4), 2'b00};
      step("R9", 1'($urandom % 4 == 0), 1'($urandom % 3 == 0), a, $urandom,
           1'($urandom % 4 == 0), 1'($urandom % 4 == 0), $urandom);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule